// File: doc/BRIEF.md
# AUX Request Sequencer with Retries

This block sits between a requester that issues native or I2C-over-AUX transactions and a channel engine that serialises bytes onto the auxiliary link. A request arrives on a valid/ready stream as a command nibble, a 20-bit address, a byte length and up to sixteen write bytes. The sequencer assembles the request header in hardware and checks that neither direction exceeds the twenty-byte channel buffer. It waits for the channel to report idle, launches the attempt and clears the engine's completion status after every attempt. Failed attempts are retried under a fixed policy.

When the last attempt finishes, one response beat goes out on a second valid/ready stream. It carries the reply nibble, the count (read payload bytes or bytes written), the read payload and a one-hot error code. Back-pressure rules: `req_ready` is high only while the sequencer is idle, so a request is taken on any cycle where both `req_valid` and `req_ready` are high. `rsp_valid` stays high, and every response field stays frozen, until a cycle with `rsp_ready` high. The next request is not accepted before that cycle.

All waits are counted in microseconds of a reference clock. `US_CYCLES` sets the number of clock cycles per microsecond, so the 1 ms busy poll spacing and the 400 µs receive-error backoff hold at any clock frequency.

Top module: `aux_req_seq`

## Requirements
- R1: Transmit byte i sits at `ch_tx_bytes[8i+7:8i]`. Byte 0 is `{cmd, addr[19:16]}`, byte 1 is `addr[15:8]`, byte 2 is `addr[7:0]` and byte 3 is length minus one.
- R2: A request of length zero sends only the three address bytes (`ch_tx_count` = 3).
- R3: Command bit 0 set means read. A write sends 4 + length bytes, with payload byte k (`req_wdata[8k+7:8k]`) at transmit byte 4+k. A read sends 4 bytes.
- R4: A request fails with the size error, and no attempt is launched, if its length exceeds `MAX_LEN`, if it would send more than 20 bytes, or if it expects more than 20 bytes back. A read expects length+1 bytes back and a write expects 2.
- R5: Before the first attempt the channel busy flag is sampled up to 3 times, with one `BUSY_WAIT_US` wait after each busy sample. If the third sample is busy, the busy error is returned after that wait and no attempt is launched. An idle sample lets the first attempt start.
- R6: A request gets at most 5 attempts. After a timeout the next attempt is launched on the cycle right after the status clear.
- R7: After a receive error (without timeout), at least `RX_WAIT_US` microseconds pass between the status clear and the next launch. There is no wait after the fifth attempt.
- R8: Each `ch_done` is followed on the next cycle by a one-cycle `ch_clear`, before any further launch or response.
- R9: If all 5 attempts fail, the error is receive error when the last attempt flagged a receive error, and timeout otherwise.
- R10: A successful attempt reporting 0 or more than 20 received bytes ends with the illegal-count error.
- R11: The reply code is received byte 0 bits 7:4. For a read, the count is min(received, length+1) − 1, and `rsp_rdata` byte j holds received byte j+1 for j below the count, with zero above it.
- R12: For a write, if at least 2 bytes are received, the count is received byte 1 clamped to the length. Otherwise the count is the length.
- R13: `rsp_err` is one-hot: bit 0 size, bit 1 busy, bit 2 timeout, bit 3 receive error, bit 4 illegal count. It is all zero on success. On an error, reply, count and data are zero.
- R14: After reset `req_ready` is high and `rsp_valid` low. The response is held stable while `rsp_ready` is low, and `req_ready` is low from acceptance until the response is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_cmd | input | 4 | Command nibble, bit 0 set for read |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Byte count of the request |
| req_wdata | input | MAX_LEN*8 | Write payload, byte k at bits 8k+7:8k |
| rsp_valid | output | 1 | Response beat available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_err | output | 5 | One-hot error code |
| rsp_reply | output | 4 | Reply nibble |
| rsp_count | output | 5 | Read payload bytes or bytes written |
| rsp_rdata | output | MAX_LEN*8 | Read payload |
| ch_busy | input | 1 | Channel still active |
| ch_start | output | 1 | One-cycle attempt launch |
| ch_tx_bytes | output | MAX_BYTES*8 | Bytes to send |
| ch_tx_count | output | 5 | Number of bytes to send |
| ch_done | input | 1 | One-cycle attempt completion |
| ch_timeout | input | 1 | Attempt timed out, valid with ch_done |
| ch_rx_err | input | 1 | Attempt had a receive error, valid with ch_done |
| ch_rx_count | input | 5 | Bytes received, valid with ch_done |
| ch_rx_bytes | input | MAX_BYTES*8 | Received bytes, valid with ch_done |
| ch_clear | output | 1 | One-cycle done/error status clear |

## Verification
The bench builds the sequencer with two clock cycles per microsecond, a ten-microsecond busy wait and a four-microsecond receive backoff. That makes a busy poll 20 cycles and a backoff 8 cycles. With these values, all three busy polls, a full five-attempt exhaustion and mixed timeout/receive-error sequences finish in a few hundred cycles, and the launch spacing can be measured exactly against those small windows. `MAX_LEN` keeps its default of 16, and the five-bit length port still reaches lengths above 16, which covers the size rejection.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;
  localparam int ERR_W       = 5;
  localparam int ERR_SIZE    = 0;
  localparam int ERR_BUSY    = 1;
  localparam int ERR_TIMEOUT = 2;
  localparam int ERR_RXERR   = 3;
  localparam int ERR_RXCNT   = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_POLL, S_POLL_WAIT, S_LAUNCH,
    S_WAIT_DONE, S_CLEAR, S_BACKOFF, S_RESP
  } seq_state_t;

  function automatic logic [ERR_W-1:0] err_bit(input int idx);
    logic [ERR_W-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/aux_seq_hdr.sv
module aux_seq_hdr #(
  parameter int MAX_LEN   = 16,
  parameter int MAX_BYTES = 20,
  parameter int LEN_W     = 5
) (
  input  logic [3:0]             cmd,
  input  logic [19:0]            addr,
  input  logic [LEN_W-1:0]       len,
  input  logic [MAX_LEN*8-1:0]   wdata,
  output logic [MAX_BYTES*8-1:0] tx_bytes,
  output logic [LEN_W-1:0]       tx_count,
  output logic [LEN_W-1:0]       rx_expect,
  output logic                   is_read,
  output logic                   size_err
);
  localparam int TOT_W = LEN_W + 2;

  logic [TOT_W-1:0] tx_tot;
  logic [TOT_W-1:0] rx_tot;

  always_comb begin
    is_read = cmd[0];
    if (len == '0)
      tx_tot = TOT_W'(3);
    else if (is_read)
      tx_tot = TOT_W'(4);
    else
      tx_tot = TOT_W'(4) + TOT_W'(len);
    rx_tot   = is_read ? (TOT_W'(len) + TOT_W'(1)) : TOT_W'(2);
    size_err = (TOT_W'(len) > TOT_W'(MAX_LEN)) ||
               (tx_tot > TOT_W'(MAX_BYTES)) ||
               (rx_tot > TOT_W'(MAX_BYTES));
    tx_count  = tx_tot[LEN_W-1:0];
    rx_expect = rx_tot[LEN_W-1:0];
  end

  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
    if (b == 0) begin : g_b0
      assign tx_bytes[7:0] = {cmd, addr[19:16]};
    end else if (b == 1) begin : g_b1
      assign tx_bytes[15:8] = addr[15:8];
    end else if (b == 2) begin : g_b2
      assign tx_bytes[23:16] = addr[7:0];
    end else if (b == 3) begin : g_b3
      assign tx_bytes[31:24] = 8'(len) - 8'd1;
    end else if (b - 4 < MAX_LEN) begin : g_pay
      assign tx_bytes[b*8 +: 8] = is_read ? 8'h00 : wdata[(b-4)*8 +: 8];
    end else begin : g_pad
      assign tx_bytes[b*8 +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/aux_seq_timer.sv
module aux_seq_timer #(
  parameter int US_CYCLES = 250,
  parameter int MAX_US    = 1000,
  localparam int US_W     = $clog2(MAX_US + 1),
  localparam int PRE_W    = (US_CYCLES > 1) ? $clog2(US_CYCLES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [US_W-1:0] load_us,
  output logic            expire
);
  logic             run;
  logic [PRE_W-1:0] pre;
  logic [US_W-1:0]  left;

  assign expire = run && (pre == '0) && (left == US_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      pre  <= '0;
      left <= '0;
    end else if (start) begin
      run  <= 1'b1;
      pre  <= PRE_W'(US_CYCLES - 1);
      left <= load_us;
    end else if (run) begin
      if (pre == '0) begin
        pre  <= PRE_W'(US_CYCLES - 1);
        left <= left - US_W'(1);
        if (left == US_W'(1)) run <= 1'b0;
      end else begin
        pre <= pre - PRE_W'(1);
      end
    end
  end

  a_r7_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (load_us != '0));
endmodule

// File: rtl/aux_seq_reply.sv
module aux_seq_reply #(
  parameter int MAX_LEN   = 16,
  parameter int MAX_BYTES = 20,
  parameter int LEN_W     = 5
) (
  input  logic [MAX_BYTES*8-1:0] rx_bytes,
  input  logic [LEN_W-1:0]       rx_count,
  input  logic [LEN_W-1:0]       rx_expect,
  input  logic [LEN_W-1:0]       len,
  input  logic                   is_read,
  output logic [3:0]             reply,
  output logic [LEN_W-1:0]       count,
  output logic [MAX_LEN*8-1:0]   rdata,
  output logic                   bad_count
);
  logic [LEN_W-1:0] eff;
  logic [LEN_W-1:0] rd_cnt;
  logic [7:0]       wr_ack;

  always_comb begin
    bad_count = (rx_count == '0) || (rx_count > LEN_W'(MAX_BYTES));
    eff       = (rx_count < rx_expect) ? rx_count : rx_expect;
    rd_cnt    = (eff == '0) ? '0 : (eff - LEN_W'(1));
    wr_ack    = rx_bytes[15:8];
    reply     = rx_bytes[7:4];
    if (is_read)
      count = rd_cnt;
    else if (eff >= LEN_W'(2))
      count = (wr_ack > 8'(len)) ? len : wr_ack[LEN_W-1:0];
    else
      count = len;
  end

  for (genvar i = 0; i < MAX_LEN; i++) begin : g_rd
    assign rdata[i*8 +: 8] = (is_read && (LEN_W'(i) < rd_cnt)) ?
                             rx_bytes[(i+1)*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/aux_req_seq.sv
module aux_req_seq
  import aux_seq_pkg::*;
#(
  parameter int MAX_LEN      = 16,
  parameter int MAX_BYTES    = 20,
  parameter int US_CYCLES    = 250,
  parameter int BUSY_WAIT_US = 1000,
  parameter int RX_WAIT_US   = 400,
  parameter int BUSY_POLLS   = 3,
  parameter int MAX_TRIES    = 5,
  localparam int LEN_W       = $clog2(MAX_BYTES + 1),
  localparam int TRY_W       = $clog2(MAX_TRIES + 1),
  localparam int POLL_W      = $clog2(BUSY_POLLS + 1),
  localparam int MAX_US      = (BUSY_WAIT_US > RX_WAIT_US) ? BUSY_WAIT_US : RX_WAIT_US,
  localparam int US_W        = $clog2(MAX_US + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [3:0]             req_cmd,
  input  logic [19:0]            req_addr,
  input  logic [LEN_W-1:0]       req_len,
  input  logic [MAX_LEN*8-1:0]   req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [ERR_W-1:0]       rsp_err,
  output logic [3:0]             rsp_reply,
  output logic [LEN_W-1:0]       rsp_count,
  output logic [MAX_LEN*8-1:0]   rsp_rdata,
  input  logic                   ch_busy,
  output logic                   ch_start,
  output logic [MAX_BYTES*8-1:0] ch_tx_bytes,
  output logic [LEN_W-1:0]       ch_tx_count,
  input  logic                   ch_done,
  input  logic                   ch_timeout,
  input  logic                   ch_rx_err,
  input  logic [LEN_W-1:0]       ch_rx_count,
  input  logic [MAX_BYTES*8-1:0] ch_rx_bytes,
  output logic                   ch_clear
);
  seq_state_t             st;
  logic [3:0]             cmd_q;
  logic [19:0]            addr_q;
  logic [LEN_W-1:0]       len_q;
  logic [MAX_LEN*8-1:0]   wdata_q;
  logic [POLL_W-1:0]      polls;
  logic [TRY_W-1:0]       tries;
  logic                   to_q;
  logic                   re_q;
  logic [LEN_W-1:0]       rxc_q;
  logic [MAX_BYTES*8-1:0] rxb_q;
  logic [ERR_W-1:0]       err_q;
  logic [3:0]             reply_q;
  logic [LEN_W-1:0]       count_q;
  logic [MAX_LEN*8-1:0]   rdata_q;

  logic                   size_err;
  logic                   is_read;
  logic [LEN_W-1:0]       rx_expect;
  logic [3:0]             dec_reply;
  logic [LEN_W-1:0]       dec_count;
  logic [MAX_LEN*8-1:0]   dec_rdata;
  logic                   dec_bad;
  logic                   tmr_start;
  logic [US_W-1:0]        tmr_load;
  logic                   tmr_expire;
  logic                   more_tries;

  aux_seq_hdr #(.MAX_LEN(MAX_LEN), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_hdr (
    .cmd(cmd_q), .addr(addr_q), .len(len_q), .wdata(wdata_q),
    .tx_bytes(ch_tx_bytes), .tx_count(ch_tx_count), .rx_expect(rx_expect),
    .is_read(is_read), .size_err(size_err)
  );

  aux_seq_reply #(.MAX_LEN(MAX_LEN), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_reply (
    .rx_bytes(rxb_q), .rx_count(rxc_q), .rx_expect(rx_expect), .len(len_q),
    .is_read(is_read), .reply(dec_reply), .count(dec_count), .rdata(dec_rdata),
    .bad_count(dec_bad)
  );

  aux_seq_timer #(.US_CYCLES(US_CYCLES), .MAX_US(MAX_US)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .load_us(tmr_load),
    .expire(tmr_expire)
  );

  assign more_tries = (tries < TRY_W'(MAX_TRIES));
  assign tmr_load   = (st == S_POLL) ? US_W'(BUSY_WAIT_US) : US_W'(RX_WAIT_US);
  assign tmr_start  = ((st == S_POLL) && ch_busy) ||
                      ((st == S_CLEAR) && !to_q && re_q && more_tries);

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESP);
  assign ch_start  = (st == S_LAUNCH);
  assign ch_clear  = (st == S_CLEAR);
  assign rsp_err   = err_q;
  assign rsp_reply = reply_q;
  assign rsp_count = count_q;
  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      wdata_q <= '0;
      polls   <= '0;
      tries   <= '0;
      to_q    <= 1'b0;
      re_q    <= 1'b0;
      rxc_q   <= '0;
      rxb_q   <= '0;
      err_q   <= '0;
      reply_q <= '0;
      count_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            cmd_q   <= req_cmd;
            addr_q  <= req_addr;
            len_q   <= req_len;
            wdata_q <= req_wdata;
            polls   <= '0;
            tries   <= '0;
            err_q   <= '0;
            reply_q <= '0;
            count_q <= '0;
            rdata_q <= '0;
            st      <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (size_err) begin
            err_q <= err_bit(ERR_SIZE);
            st    <= S_RESP;
          end else begin
            st <= S_POLL;
          end
        end
        S_POLL: begin
          if (!ch_busy) begin
            st <= S_LAUNCH;
          end else begin
            polls <= polls + POLL_W'(1);
            st    <= S_POLL_WAIT;
          end
        end
        S_POLL_WAIT: begin
          if (tmr_expire) begin
            if (polls == POLL_W'(BUSY_POLLS)) begin
              err_q <= err_bit(ERR_BUSY);
              st    <= S_RESP;
            end else begin
              st <= S_POLL;
            end
          end
        end
        S_LAUNCH: begin
          tries <= tries + TRY_W'(1);
          st    <= S_WAIT_DONE;
        end
        S_WAIT_DONE: begin
          if (ch_done) begin
            to_q  <= ch_timeout;
            re_q  <= ch_rx_err;
            rxc_q <= ch_rx_count;
            rxb_q <= ch_rx_bytes;
            st    <= S_CLEAR;
          end
        end
        S_CLEAR: begin
          if (to_q) begin
            if (more_tries) begin
              st <= S_LAUNCH;
            end else begin
              err_q <= re_q ? err_bit(ERR_RXERR) : err_bit(ERR_TIMEOUT);
              st    <= S_RESP;
            end
          end else if (re_q) begin
            if (more_tries) begin
              st <= S_BACKOFF;
            end else begin
              err_q <= err_bit(ERR_RXERR);
              st    <= S_RESP;
            end
          end else if (dec_bad) begin
            err_q <= err_bit(ERR_RXCNT);
            st    <= S_RESP;
          end else begin
            reply_q <= dec_reply;
            count_q <= dec_count;
            rdata_q <= dec_rdata;
            st      <= S_RESP;
          end
        end
        S_BACKOFF: begin
          if (tmr_expire) st <= S_LAUNCH;
        end
        S_RESP: begin
          if (rsp_ready) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r13_err_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(rsp_err));

  a_r14_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_err) &&
      $stable(rsp_count) && $stable(rsp_reply) && $stable(rsp_rdata)));

  a_r8_clear_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    ch_clear |-> $past(ch_done));

  a_r4_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ch_start |-> ((ch_tx_count <= LEN_W'(MAX_BYTES)) && (ch_tx_count >= LEN_W'(3))));

  a_r6_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ch_start |-> more_tries);
endmodule

// File: tb/aux_req_seq_test.sv
module aux_req_seq_test;
  localparam int US_CYC = 2;
  localparam int BUSY_US = 10;
  localparam int RX_US = 4;
  localparam int BUSY_CYC = US_CYC * BUSY_US;
  localparam int RX_CYC = US_CYC * RX_US;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [3:0]   req_cmd = '0;
  logic [19:0]  req_addr = '0;
  logic [4:0]   req_len = '0;
  logic [127:0] req_wdata = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b0;
  logic [4:0]   rsp_err;
  logic [3:0]   rsp_reply;
  logic [4:0]   rsp_count;
  logic [127:0] rsp_rdata;
  logic         ch_busy = 1'b0;
  logic         ch_start;
  logic [159:0] ch_tx_bytes;
  logic [4:0]   ch_tx_count;
  logic         ch_done = 1'b0;
  logic         ch_timeout = 1'b0;
  logic         ch_rx_err = 1'b0;
  logic [4:0]   ch_rx_count = '0;
  logic [159:0] ch_rx_bytes = '0;
  logic         ch_clear;

  aux_req_seq #(.US_CYCLES(US_CYC), .BUSY_WAIT_US(BUSY_US), .RX_WAIT_US(RX_US)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_reply(rsp_reply), .rsp_count(rsp_count), .rsp_rdata(rsp_rdata),
    .ch_busy(ch_busy), .ch_start(ch_start), .ch_tx_bytes(ch_tx_bytes),
    .ch_tx_count(ch_tx_count), .ch_done(ch_done), .ch_timeout(ch_timeout),
    .ch_rx_err(ch_rx_err), .ch_rx_count(ch_rx_count), .ch_rx_bytes(ch_rx_bytes),
    .ch_clear(ch_clear)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // scripted engine outcomes, one per attempt
  bit           s_to [8];
  bit           s_re [8];
  int           s_cnt [8];
  logic [159:0] s_rx [8];

  int att_idx = 0;
  int eng_wait = 0;
  int n_start = 0;
  int last_clear = 0;
  int prev_kind = 0;  // 0 ok, 1 timeout, 2 receive error
  bit prev_done = 1'b0;
  int rsp_cyc = -1;
  logic [159:0] cap_tx;
  logic [4:0]   cap_txc;

  logic [4:0]   e_err;
  logic [3:0]   e_reply;
  logic [4:0]   e_count;
  logic [127:0] e_data;
  int           e_starts;
  logic [159:0] e_tx;
  int           e_txc;

  task automatic chk(input bit ok, input string tag, input logic [159:0] act,
                     input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // channel engine model and per-cycle monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      prev_done = ch_done;
      ch_done = 1'b0;
      if (cyc > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
      if (eng_wait > 0) begin
        eng_wait--;
        if (eng_wait == 0) begin
          ch_done = 1'b1;
          ch_timeout = s_to[att_idx];
          ch_rx_err = s_re[att_idx];
          ch_rx_count = 5'(s_cnt[att_idx]);
          ch_rx_bytes = s_rx[att_idx];
          att_idx++;
        end
      end
      if (ch_clear) begin
        if (!prev_done) chk(1'b0, "R8 clear without done", 0, 1);
        last_clear = cyc;
      end
      if (ch_start) begin
        n_start++;
        if (ch_busy) chk(1'b0, "R5 launch while busy", 1, 0);
        if (n_start == 1) begin
          cap_tx = ch_tx_bytes;
          cap_txc = ch_tx_count;
        end else if (prev_kind == 1) begin
          chk(cyc - last_clear == 1, "R6 retry gap after timeout", cyc - last_clear, 1);
        end else if (prev_kind == 2) begin
          chk(cyc - last_clear >= RX_CYC, "R7 retry gap after receive error",
              cyc - last_clear, RX_CYC);
        end
        prev_kind = s_to[att_idx] ? 1 : (s_re[att_idx] ? 2 : 0);
        eng_wait = 3;
      end
      if (rsp_valid && rsp_cyc < 0) rsp_cyc = cyc;
    end
  end

  task automatic script_reset();
    for (int i = 0; i < 8; i++) begin
      s_to[i] = 1'b0; s_re[i] = 1'b0; s_cnt[i] = 1; s_rx[i] = '0;
    end
  endtask

  task automatic model(input logic [3:0] cmd, input logic [19:0] addr,
                       input int len, input logic [127:0] wd, input bit busy_always);
    bit rd;
    int rxe, cnt, eff;
    logic [159:0] b;
    rd = cmd[0];
    e_txc = (len == 0) ? 3 : (rd ? 4 : 4 + len);
    rxe = rd ? len + 1 : 2;
    e_tx = '0;
    e_tx[7:0] = {cmd, addr[19:16]};
    e_tx[15:8] = addr[15:8];
    e_tx[23:16] = addr[7:0];
    e_tx[31:24] = 8'(len - 1);
    if (!rd) for (int k = 0; k < len && k < 16; k++) e_tx[(4+k)*8 +: 8] = wd[k*8 +: 8];
    e_err = '0; e_reply = '0; e_count = '0; e_data = '0; e_starts = 0;
    if (len > 16 || e_txc > 20 || rxe > 20) begin e_err = 5'b00001; return; end
    if (busy_always) begin e_err = 5'b00010; return; end
    for (int a = 0; a < 5; a++) begin
      e_starts++;
      if (s_to[a]) begin
        if (a == 4) e_err = s_re[a] ? 5'b01000 : 5'b00100;
        continue;
      end
      if (s_re[a]) begin
        if (a == 4) e_err = 5'b01000;
        continue;
      end
      cnt = s_cnt[a];
      if (cnt == 0 || cnt > 20) begin e_err = 5'b10000; break; end
      eff = (cnt < rxe) ? cnt : rxe;
      b = s_rx[a];
      e_reply = b[7:4];
      if (rd) begin
        e_count = 5'(eff - 1);
        for (int k = 0; k < eff - 1; k++) e_data[k*8 +: 8] = b[(k+1)*8 +: 8];
      end else if (eff >= 2) begin
        e_count = (int'(b[15:8]) > len) ? 5'(len) : b[12:8];
      end else begin
        e_count = 5'(len);
      end
      break;
    end
  endtask

  task automatic run(input string tag, input logic [3:0] cmd, input logic [19:0] addr,
                     input int len, input logic [127:0] wd, input int busy_cycles,
                     input bit hold);
    int acc;
    logic [4:0] h_err, h_cnt;
    model(cmd, addr, len, wd, busy_cycles < 0);
    n_start = 0; att_idx = 0; rsp_cyc = -1; prev_kind = 0;
    @(negedge clk);
    chk(req_ready, {tag, " R14 ready when idle"}, req_ready, 1);
    ch_busy = (busy_cycles != 0);
    req_cmd = cmd; req_addr = addr; req_len = 5'(len); req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    acc = cyc;
    while (!rsp_valid) begin
      if (busy_cycles > 0 && cyc - acc >= busy_cycles) ch_busy = 1'b0;
      if (req_ready) chk(1'b0, {tag, " R14 ready while working"}, 1, 0);
      @(negedge clk);
    end
    if (hold) begin
      h_err = rsp_err; h_cnt = rsp_count;
      repeat (4) @(negedge clk);
      chk(rsp_valid && rsp_err == h_err && rsp_count == h_cnt && !req_ready,
          {tag, " R14 response held"}, {rsp_valid, rsp_err, rsp_count},
          {1'b1, h_err, h_cnt});
    end
    chk(rsp_err == e_err, {tag, " R13 error code"}, rsp_err, e_err);
    chk(rsp_reply == e_reply && rsp_count == e_count, {tag, " R11 R12 reply/count"},
        {rsp_reply, rsp_count}, {e_reply, e_count});
    chk(rsp_rdata == e_data, {tag, " R11 read data"}, rsp_rdata, e_data);
    chk(n_start == e_starts, {tag, " R6 attempt count"}, n_start, e_starts);
    if (e_starts > 0) begin
      chk(int'(cap_txc) == e_txc, {tag, " R2 R3 tx count"}, cap_txc, e_txc);
      for (int k = 0; k < e_txc; k++)
        if (cap_tx[k*8 +: 8] != e_tx[k*8 +: 8])
          chk(1'b0, {tag, " R1 R3 header byte"}, cap_tx[k*8 +: 8], e_tx[k*8 +: 8]);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    ch_busy = 1'b0;
    acc = rsp_cyc - acc;
    if (busy_cycles < 0)
      chk(acc >= 3 * BUSY_CYC, {tag, " R5 busy wait length"}, acc, 3 * BUSY_CYC);
  endtask

  initial begin
    script_reset();
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !ch_start && !ch_clear, "R14 reset state",
        {req_ready, rsp_valid, ch_start, ch_clear}, 4'b1000);
    rst_n = 1'b1;

    // native write, short-write ack absent, back-pressure on response
    script_reset(); s_cnt[0] = 1; s_rx[0] = 160'h50;
    run("wr_full", 4'h8, 20'h12345, 3, 128'h33_22_11, 0, 1'b1);
    // write with partial-ack byte, and with over-range ack clamped
    script_reset(); s_cnt[0] = 2; s_rx[0] = 160'h02_00;
    run("wr_short", 4'h8, 20'hA0001, 5, 128'h55_44_33_22_11, 0, 1'b0);
    script_reset(); s_cnt[0] = 2; s_rx[0] = 160'h09_00;
    run("wr_clamp R12", 4'h0, 20'h00050, 3, 128'hCC_BB_AA, 0, 1'b0);
    // native read full and short
    script_reset(); s_cnt[0] = 5; s_rx[0] = 160'hDD_CC_BB_AA_20;
    run("rd_full R11", 4'h9, 20'hF00AB, 4, '0, 0, 1'b0);
    script_reset(); s_cnt[0] = 4; s_rx[0] = 160'h77_66_55_44_33_22_11_00;
    run("rd_short R11", 4'h9, 20'h00200, 8, '0, 0, 1'b0);
    // zero-length I2C read (address-only)
    script_reset(); s_cnt[0] = 1; s_rx[0] = 160'h10;
    run("zero_len R2", 4'h1, 20'h00050, 0, '0, 0, 1'b0);
    // size rejections
    script_reset();
    run("size_wr R4", 4'h8, 20'h00001, 17, '1, 0, 1'b0);
    run("size_rd R4", 4'h9, 20'h00001, 20, '0, 0, 1'b0);
    // timeouts then success
    script_reset(); s_to[0] = 1; s_to[1] = 1; s_cnt[2] = 1; s_rx[2] = 160'h00;
    run("to_retry R6", 4'h8, 20'h00010, 1, 128'h5A, 0, 1'b0);
    // receive error then success
    script_reset(); s_re[0] = 1; s_cnt[1] = 3; s_rx[1] = 160'h BEEF_00;
    run("re_retry R7", 4'h9, 20'h00011, 2, '0, 0, 1'b0);
    // exhausted by timeouts
    script_reset(); for (int i = 0; i < 5; i++) s_to[i] = 1;
    run("to_all R9", 4'h8, 20'h00012, 1, 128'h01, 0, 1'b0);
    // last attempt receive error, no trailing wait
    script_reset(); for (int i = 0; i < 4; i++) s_to[i] = 1; s_re[4] = 1;
    run("re_last R9", 4'h8, 20'h00013, 1, 128'h02, 0, 1'b0);
    chk(rsp_cyc - last_clear == 1, "R7 no wait after last attempt", rsp_cyc - last_clear, 1);
    // both flags on final attempt: receive error wins
    script_reset(); for (int i = 0; i < 5; i++) s_to[i] = 1; s_re[4] = 1;
    run("both_last R9", 4'h9, 20'h00014, 1, '0, 0, 1'b0);
    // illegal receive counts
    script_reset(); s_cnt[0] = 0;
    run("cnt0 R10", 4'h9, 20'h00015, 2, '0, 0, 1'b0);
    script_reset(); s_cnt[0] = 21;
    run("cnt21 R10", 4'h8, 20'h00016, 2, 128'h1234, 0, 1'b0);
    // busy channel forever, then busy released during the wait
    script_reset();
    run("busy_all R5", 4'h8, 20'h00017, 1, 128'h9, -1, 1'b0);
    script_reset(); s_cnt[0] = 1; s_rx[0] = 160'h00;
    run("busy_free R5", 4'h8, 20'h00018, 1, 128'h9, BUSY_CYC + 5, 1'b0);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule